// File: doc/BRIEF.md
# Host-Fed Burst DMA Write Bridge

A host processor fills a small queue of 16-bit words through a data port. A single DMA channel copies those words into the memory of a second processor through a write port with a valid/ready handshake. The host side has a control register and a transfer-length register. The DMA side has a destination address, a 24-bit transfer count, a two-bit channel control field and a global enable. The queue is not drained one word at a time. A drain starts only when the number of queued words is a whole multiple of the burst size and the channel is armed. The drain then empties the queue.

Each word that goes out advances the destination address by one 16-bit word. Each such word also lowers two separate counters: the host-visible length and the channel count. When a counter reaches zero at the end of a drain, it updates its own status bit. The host length at zero clears the host enable. The channel count at zero marks the channel done. The queue is cleared at the end of every drain. The host watches the full flag and its length register to pace its writes.

Top module: `push_dma_bridge`

## Requirements
- R1: After reset, every register is zero, the queue is empty, `fifo_full` is low and `mem_valid` is low.
- R2: A write to the data port (`host_sel`=2) is dropped in three cases: `xfer_en` is low, the queue already holds DEPTH words, or a drain is in progress.
- R3: A write to the length register (`host_sel`=1) stores the data with bits 1:0 forced to zero.
- R4: A drain starts in the cycle after the queue holds a nonzero multiple of BURST words while `chan_ctl` equals 2'b01 and the global enable bit (bit 0 of the `cfg_sel`=3 write) is set. It does not start otherwise.
- R5: Words leave in the order they were queued. Each word is presented at `dest_addr`. After each accepted beat, `dest_addr` rises by 2, `chan_count` falls by 1 and `host_len` falls by 1. `host_len` stops at zero.
- R6: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` stay unchanged.
- R7: `fifo_full` is high exactly when the queue holds DEPTH words. After any drain the queue is empty and `fifo_full` is low.
- R8: A drain ends when the queued words run out or when `chan_count` reaches zero. Any words still queued at that point are discarded.
- R9: If `host_len` is zero when a drain ends, `xfer_en` is cleared.
- R10: If `chan_count` is zero when a drain ends, `chan_ctl` bit 1 (done) is set. While it stays set, no new drain starts.
- R11: A control write (`host_sel`=0) loads `xfer_en` from bit 0, `dma_flag` from bit 1 and `rv_flag` from bit 2. It leaves `fifo_full` and the queue contents unchanged.
- R12: The channel count (`cfg_sel`=1) keeps only the low 24 bits of the written data. `cfg_sel`=0 loads the destination address and `cfg_sel`=2 loads `chan_ctl` from bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select: 0 control, 1 length, 2 data port |
| host_wdata | input | 16 | Host write data |
| xfer_en | output | 1 | Host transfer enable |
| dma_flag | output | 1 | Host DMA mode bit |
| rv_flag | output | 1 | Host RV bit |
| fifo_full | output | 1 | Queue holds DEPTH words |
| host_len | output | 16 | Host-visible remaining length |
| cfg_we | input | 1 | Channel configuration write strobe |
| cfg_sel | input | 2 | Select: 0 destination, 1 count, 2 channel control, 3 global enable |
| cfg_wdata | input | 32 | Configuration write data |
| dest_addr | output | 32 | Current destination address |
| chan_count | output | 24 | Remaining channel count |
| chan_ctl | output | 2 | Channel control: bit 0 enable, bit 1 done |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 16 | Memory write data |

## Verification
The bench keeps a queue-based model and covers several corner cases. In one, the channel count expires partway through a burst. A design that kept the remaining words would replay stale data on the next drain. In another, the done bit must block the next burst. In another, a drain is started by arming the channel after the queue was already full, rather than by a data write. Back-to-back data writes during a drain must be dropped; a design that accepted them would corrupt the drained order. A random `mem_ready` pattern checks that a stalled beat keeps its address and data. The bench also checks the host length running out before the channel count, which must clear the enable while later writes are refused.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

  typedef enum logic [1:0] {
    HS_CTRL = 2'd0,
    HS_LEN  = 2'd1,
    HS_DATA = 2'd2,
    HS_NONE = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    CS_DEST   = 2'd0,
    CS_COUNT  = 2'd1,
    CS_CHCTL  = 2'd2,
    CS_GLOBAL = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } drain_state_e;

endpackage

// File: rtl/pdb_fifo.sv
module pdb_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              flush,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level
);

  logic [LVL_W-1:0]        level_q, level_d;
  logic [DEPTH*DATA_W-1:0] flat;
  logic                    wr_ok;

  assign wr_ok = push && (level_q < LVL_W'(DEPTH));

  always_comb begin
    level_d = level_q;
    if (flush)      level_d = '0;
    else if (wr_ok) level_d = level_q + LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gen_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (wr_ok && (level_q == LVL_W'(g))) slot_q <= push_data;
    end
    assign flat[g*DATA_W +: DATA_W] = slot_q;
  end

  assign rd_data = flat[rd_idx*DATA_W +: DATA_W];
  assign level   = level_q;

endmodule

// File: rtl/pdb_host_regs.sv
module pdb_host_regs #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              len_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              beat,
  input  logic              finish,
  output logic              xfer_en,
  output logic              dma_flag,
  output logic              rv_flag,
  output logic [LEN_W-1:0]  host_len
);

  logic [2:0]       ctl_q, ctl_d;
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    len_d = len_q;
    if (len_we)                       len_d = wdata[LEN_W-1:0] & ~LEN_W'(3);
    else if (beat && len_q != '0)     len_d = len_q - LEN_W'(1);

    ctl_d = ctl_q;
    if (ctrl_we)                      ctl_d = wdata[2:0];
    if (finish && len_d == '0)        ctl_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      len_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      len_q <= len_d;
    end
  end

  assign xfer_en  = ctl_q[0];
  assign dma_flag = ctl_q[1];
  assign rv_flag  = ctl_q[2];
  assign host_len = len_q;

endmodule

// File: rtl/pdb_channel.sv
module pdb_channel
  import pdb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              beat,
  input  logic              finish,
  output logic [ADDR_W-1:0] dest_addr,
  output logic [CNT_W-1:0]  chan_count,
  output logic [1:0]        chan_ctl,
  output logic              glob_en
);

  logic [ADDR_W-1:0] dest_q, dest_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        ctl_q, ctl_d;
  logic              gen_q, gen_d;

  always_comb begin
    dest_d = dest_q;
    cnt_d  = cnt_q;
    ctl_d  = ctl_q;
    gen_d  = gen_q;

    if (cfg_we && cfg_sel == CS_DEST)   dest_d = cfg_wdata[ADDR_W-1:0];
    else if (beat)                      dest_d = dest_q + ADDR_W'(2);

    if (cfg_we && cfg_sel == CS_COUNT)  cnt_d = cfg_wdata[CNT_W-1:0];
    else if (beat)                      cnt_d = cnt_q - CNT_W'(1);

    if (cfg_we && cfg_sel == CS_CHCTL)  ctl_d = cfg_wdata[1:0];
    if (finish && cnt_d == '0)          ctl_d[1] = 1'b1;

    if (cfg_we && cfg_sel == CS_GLOBAL) gen_d = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      gen_q  <= 1'b0;
    end else begin
      dest_q <= dest_d;
      cnt_q  <= cnt_d;
      ctl_q  <= ctl_d;
      gen_q  <= gen_d;
    end
  end

  assign dest_addr  = dest_q;
  assign chan_count = cnt_q;
  assign chan_ctl   = ctl_q;
  assign glob_en    = gen_q;

endmodule

// File: rtl/push_dma_bridge.sv
module push_dma_bridge
  import pdb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int LEN_W  = 16,
  parameter int CFG_W  = 32,
  parameter int DEPTH  = 8,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              xfer_en,
  output logic              dma_flag,
  output logic              rv_flag,
  output logic              fifo_full,
  output logic [LEN_W-1:0]  host_len,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0] dest_addr,
  output logic [CNT_W-1:0]  chan_count,
  output logic [1:0]        chan_ctl,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  drain_state_e     state_q, state_d;
  logic [LVL_W-1:0] idx_q, idx_d;
  logic [LVL_W-1:0] level;
  logic [DATA_W-1:0] rd_data;
  logic             busy, push, trigger, beat, last, finish, glob_en;

  assign busy = (state_q == ST_DRAIN);
  assign push = host_we && (host_sel == HS_DATA) && xfer_en && !busy;

  assign trigger = !busy && (level != '0)
                && ((32'(level) % BURST) == 0)
                && (chan_ctl == 2'b01) && glob_en;

  assign mem_valid = busy && (idx_q < level) && (chan_count != '0);
  assign beat      = mem_valid && mem_ready;
  assign last      = ((idx_q + LVL_W'(1)) == level) || (chan_count == CNT_W'(1));
  assign finish    = busy && (!mem_valid || (beat && last));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (trigger) begin
      state_d = ST_DRAIN;
      idx_d   = '0;
    end else if (finish) begin
      state_d = ST_IDLE;
    end else if (beat) begin
      idx_d = idx_q + LVL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  pdb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (host_wdata),
    .flush     (finish),
    .rd_idx    (idx_q[IDX_W-1:0]),
    .rd_data   (rd_data),
    .level     (level)
  );

  pdb_host_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (host_we && host_sel == HS_CTRL),
    .len_we   (host_we && host_sel == HS_LEN),
    .wdata    (host_wdata),
    .beat     (beat),
    .finish   (finish),
    .xfer_en  (xfer_en),
    .dma_flag (dma_flag),
    .rv_flag  (rv_flag),
    .host_len (host_len)
  );

  pdb_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .beat       (beat),
    .finish     (finish),
    .dest_addr  (dest_addr),
    .chan_count (chan_count),
    .chan_ctl   (chan_ctl),
    .glob_en    (glob_en)
  );

  assign fifo_full = (level == LVL_W'(DEPTH));
  assign mem_addr  = dest_addr;
  assign mem_data  = rd_data;

endmodule

// File: rtl/push_dma_bridge_chk.sv
module push_dma_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [1:0]        host_sel,
  input logic              xfer_en,
  input logic              cfg_we,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [ADDR_W-1:0] dest_addr,
  input logic [1:0]        chan_ctl,
  input logic              fifo_full,
  input logic [LVL_W-1:0]  level,
  input logic              busy
);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && !cfg_we |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !cfg_we |=> dest_addr == $past(dest_addr) + ADDR_W'(2));

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R7
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !busy |=> fifo_full);

  // R2
  gate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_sel == 2'd2 && !xfer_en && !busy |=> $stable(level));

  // R13 of the data-during-drain rule is folded into R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && host_we && host_sel == 2'd2 |=> level <= $past(level));

  // R10
  done_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && chan_ctl[1] |=> !busy);

  // R8
  flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> level == '0);

endmodule

bind push_dma_bridge push_dma_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_we   (host_we),
  .host_sel  (host_sel),
  .xfer_en   (xfer_en),
  .cfg_we    (cfg_we),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .dest_addr (dest_addr),
  .chan_ctl  (chan_ctl),
  .fifo_full (fifo_full),
  .level     (level),
  .busy      (busy)
);

// File: tb/push_dma_bridge_tb.sv
module push_dma_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd3;
  logic [15:0] host_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_ready = 1'b1;
  logic        xfer_en, dma_flag, rv_flag, fifo_full, mem_valid;
  logic [15:0] host_len, mem_data;
  logic [31:0] dest_addr, mem_addr;
  logic [23:0] chan_count;
  logic [1:0]  chan_ctl;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  cmp_on   = 1'b0;
  bit  rdy_rand = 1'b0;

  always #2 clk = ~clk;

  push_dma_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .xfer_en(xfer_en), .dma_flag(dma_flag), .rv_flag(rv_flag),
    .fifo_full(fifo_full), .host_len(host_len),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dest_addr(dest_addr), .chan_count(chan_count), .chan_ctl(chan_ctl),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // behavioural reference state
  int          mq[$];
  bit          mdrain;
  int          midx;
  bit          men, mdma, mrv, mgen;
  logic [15:0] mlen;
  logic [31:0] mdest;
  logic [23:0] mcnt;
  logic [1:0]  mchcr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); mdrain = 0; midx = 0;
      men = 0; mdma = 0; mrv = 0; mgen = 0;
      mlen = '0; mdest = '0; mcnt = '0; mchcr = '0;
    end else begin
      bit v, bt, fin, nen, ndma, nrv, ngen;
      logic [15:0] nlen;
      logic [31:0] ndest;
      logic [23:0] ncnt;
      logic [1:0]  nchcr;
      v  = mdrain && (midx < mq.size()) && (mcnt != 0);
      bt = v && mem_ready;
      nlen = mlen; ndest = mdest; ncnt = mcnt; nchcr = mchcr; ngen = mgen;
      nen = men; ndma = mdma; nrv = mrv;
      if (host_we && host_sel == 2'd1)      nlen = host_wdata & 16'hfffc;
      else if (bt && mlen != 0)             nlen = mlen - 1;
      if (host_we && host_sel == 2'd0) begin
        nen = host_wdata[0]; ndma = host_wdata[1]; nrv = host_wdata[2];
      end
      if (cfg_we && cfg_sel == 2'd0)        ndest = cfg_wdata;
      else if (bt)                          ndest = mdest + 2;
      if (cfg_we && cfg_sel == 2'd1)        ncnt = cfg_wdata[23:0];
      else if (bt)                          ncnt = mcnt - 1;
      if (cfg_we && cfg_sel == 2'd2)        nchcr = cfg_wdata[1:0];
      if (cfg_we && cfg_sel == 2'd3)        ngen = cfg_wdata[0];
      if (mdrain) begin
        fin = !v || (bt && ((midx + 1 == mq.size()) || (mcnt == 1)));
        if (bt) midx = midx + 1;
        if (fin) begin
          mq.delete(); mdrain = 0;
          if (nlen == 0) nen = 0;
          if (ncnt == 0) nchcr[1] = 1'b1;
        end
      end else begin
        if (mq.size() > 0 && (mq.size() % 4) == 0 && mchcr == 2'b01 && mgen) begin
          mdrain = 1; midx = 0;
        end
        if (host_we && host_sel == 2'd2 && men && mq.size() < 8)
          mq.push_back(int'(host_wdata));
      end
      mlen = nlen; mdest = ndest; mcnt = ncnt; mchcr = nchcr; mgen = ngen;
      men = nen; mdma = ndma; mrv = nrv;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      bit ev;
      ev = mdrain && (midx < mq.size()) && (mcnt != 0);
      check("R4 R8 mem_valid", 32'(mem_valid), 32'(ev));
      if (ev) begin
        check("R5 mem_addr", mem_addr, mdest);
        check("R5 R6 mem_data", 32'(mem_data), 32'(mq[midx]));
      end
      check("R7 fifo_full", 32'(fifo_full), 32'(mq.size() == 8));
      check("R9 R11 xfer_en", 32'(xfer_en), 32'(men));
      check("R11 dma_flag", 32'(dma_flag), 32'(mdma));
      check("R11 rv_flag", 32'(rv_flag), 32'(mrv));
      check("R3 R5 host_len", 32'(host_len), 32'(mlen));
      check("R5 dest_addr", dest_addr, mdest);
      check("R12 chan_count", 32'(chan_count), 32'(mcnt));
      check("R10 chan_ctl", 32'(chan_ctl), 32'(mchcr));
    end
  end

  always @(negedge clk) mem_ready <= rdy_rand ? 1'($urandom % 2) : 1'b1;

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hwr(logic [1:0] sel, logic [15:0] d);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_sel = 2'd3;
  endtask

  task automatic cwr(logic [1:0] sel, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_n(int n, logic [15:0] base);
    for (int i = 0; i < n; i++) hwr(2'd2, base + 16'(i));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 60000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 xfer_en", 32'(xfer_en), 0);
    check("R1 host_len", 32'(host_len), 0);
    check("R1 dest_addr", dest_addr, 0);
    check("R1 chan_count", 32'(chan_count), 0);
    check("R1 chan_ctl", 32'(chan_ctl), 0);
    check("R1 mem_valid", 32'(mem_valid), 0);
    check("R1 fifo_full", 32'(fifo_full), 0);
    cmp_on = 1'b1;

    // R2: data writes with the enable low are dropped
    push_n(3, 16'h0a00);
    cwr(2'd0, 32'h0000_1000);
    cwr(2'd1, 32'hff00_0020);       // R12: upper bits dropped
    cwr(2'd2, 32'h1);
    cwr(2'd3, 32'h1);
    hwr(2'd1, 16'h0013);            // R3: stored as 0x10
    hwr(2'd0, 16'h0007);            // R11
    // R4 R5: first burst of four
    push_n(4, 16'h1100);
    tick(10);

    // R2: writes during a drain are dropped; random ready exercises R6
    rdy_rand = 1'b1;
    push_n(8, 16'h2200);
    tick(30);
    rdy_rand = 1'b0;

    // R7 full with channel disarmed, extra write dropped, R11 keeps full
    cwr(2'd2, 32'h0);
    push_n(9, 16'h3300);
    hwr(2'd0, 16'h0001);
    tick(3);
    // R4: arming the channel starts a drain of the full queue; R9 len hits zero
    cwr(2'd2, 32'h1);
    tick(16);

    // R8 R10: count expires mid-burst, leftover words discarded, done blocks
    hwr(2'd0, 16'h0001);
    hwr(2'd1, 16'h0040);
    cwr(2'd1, 32'h2);
    push_n(4, 16'h4400);
    tick(8);
    cwr(2'd1, 32'h10);
    push_n(4, 16'h5500);
    tick(8);
    cwr(2'd2, 32'h1);
    tick(10);

    // R4: global enable off blocks the burst
    cwr(2'd3, 32'h0);
    push_n(4, 16'h6600);
    tick(6);
    cwr(2'd3, 32'h1);
    tick(10);

    // R9: host length runs out first, enable drops, later writes refused (R2)
    hwr(2'd1, 16'h0004);
    rdy_rand = 1'b1;
    push_n(4, 16'h7700);
    tick(16);
    push_n(4, 16'h8800);
    tick(8);
    rdy_rand = 1'b0;
    check("R9 xfer_en after length ran out", 32'(xfer_en), 0);

    tick(4);
    finish_run();
  end

endmodule